// File: doc/BRIEF.md
# PHY Soft Reset Sequencer

This block drives the soft reset of an Ethernet PHY from two self-clearing control bits that software can write. One bit is in a power-management control register and gives a long reset that clears all PHY state. The other is bit 15 of the PHY basic control register and gives a short reset. That reset leaves a marked class of sticky register bits untouched. Each bit reads back 1 while its reset runs. The bit drops to 0 by itself when the reset ends, and that is how software learns the reset is done.

Both durations are counted in microsecond ticks supplied from outside: 2000 ticks for the long reset and 256 for the short one by default. An optional prescaler divides a faster strobe down to the counted tick. A long request that arrives during a short reset upgrades it: the counter reloads with the long duration, and both bits clear together when it expires. The reset output goes to the PHY logic. The sticky-clear qualifier tells the sticky register bits whether this reset may clear them. The chip-level hard reset is a separate input that clears everything.

Top module: `phy_srst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `pm_rst_bit`, `bc_rst_bit`, `phy_soft_rst` and `sticky_clr` are all 0.
- R2: A clock edge that samples `pm_wr_en`=1 with `pm_wr_data`=1 while no reset runs makes `pm_rst_bit`, `phy_soft_rst` and `sticky_clr` read 1 after that same edge.
- R3: A long reset ends on the edge that samples its LONG_TICKS-th counted tick after the start edge. On that edge `pm_rst_bit`, `phy_soft_rst` and `sticky_clr` drop to 0. Clock edges with no tick do not advance the count.
- R4: A clock edge that samples `bc_wr_en`=1 with `bc_wr_data`=1 while no reset runs makes `bc_rst_bit` and `phy_soft_rst` read 1 after that edge. `sticky_clr` stays 0 throughout the short reset.
- R5: A short reset ends on the edge that samples its SHORT_TICKS-th counted tick after the start edge, clearing `bc_rst_bit` and `phy_soft_rst`.
- R6: A write with data 0 to either bit changes neither bit and leaves the reset timing unchanged, both when idle and while a reset runs.
- R7: Writing 1 to a bit whose own reset is already running does not restart it. The end still falls on the tick counted from the original start.
- R8: A long request during a short reset reloads the counter with LONG_TICKS counted from that write edge. `pm_rst_bit` and `sticky_clr` rise, `bc_rst_bit` stays 1, and both bits clear on the same edge.
- R9: Writing 1 to the basic-control bit during a long reset is ignored: `bc_rst_bit` stays 0.
- R10: Writes of 1 to both bits on the same edge while idle start a long reset with both bits set. Both clear together after LONG_TICKS.
- R11: `phy_soft_rst` is 1 exactly when `pm_rst_bit` or `bc_rst_bit` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip-level hard reset, active low |
| tick_us | input | 1 | Time-base strobe, one clock wide (one microsecond when TICK_DIV=1) |
| pm_wr_en | input | 1 | Write strobe for the power-management reset bit |
| pm_wr_data | input | 1 | Value written to the power-management reset bit |
| bc_wr_en | input | 1 | Write strobe for basic control bit 15 |
| bc_wr_data | input | 1 | Value written to basic control bit 15 |
| pm_rst_bit | output | 1 | Read-back of the power-management reset bit |
| bc_rst_bit | output | 1 | Read-back of basic control bit 15 |
| phy_soft_rst | output | 1 | Soft reset to the PHY logic, active high |
| sticky_clr | output | 1 | High when the running reset may also clear the sticky register bits |

## Verification
The assertions assume that the tick and the write strobes are clean, single-clock-domain levels sampled at the rising edge. They also assume a tick is the only thing that can end a reset, so any bit change on an edge with no tick and no write of 1 is treated as an error. The bench changes every input only at the falling edge and holds each write strobe for exactly one rising edge. It gives ticks as runs of consecutive one-clock strobes whose count it knows. It also waits through long stretches with no tick at all, so every expected edge can be found by counting ticks from the write.

// File: rtl/phy_srst_pkg.sv
package phy_srst_pkg;

   // Sequencer state: which kind of soft reset is running
   typedef enum logic [1:0] {
      SR_IDLE  = 2'd0,
      SR_SHORT = 2'd1,
      SR_LONG  = 2'd2
   } sr_mode_t;

   // Index of each trigger bit in the flag vectors
   localparam int unsigned SRC_PM = 0;
   localparam int unsigned SRC_BC = 1;
   localparam int unsigned N_SRC  = 2;

   // Width needed to hold the value n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/srst_tick_gen.sv
module srst_tick_gen #(
   parameter int unsigned TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);

   generate
      if (TICK_DIV == 1) begin : g_pass
         assign tick_out = tick_in;
      end else begin : g_div
         localparam int unsigned DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (tick_in) begin
               div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
            end
         end

         assign tick_out = tick_in && (div_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/srst_dur_cnt.sv
module srst_dur_cnt #(
   parameter int unsigned CNT_W       = 11,
   parameter int unsigned LONG_TICKS  = 2000,
   parameter int unsigned SHORT_TICKS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_long,
   input  logic             run,
   input  logic             tick,
   output logic             expire,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_TICKS);
   localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_TICKS);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   // The last tick of a running reset
   assign expire = run && tick && (cnt_q == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_long ? LONG_V : SHORT_V;
      end else if (expire) begin
         cnt_q <= '0;
      end else if (run && tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
   import phy_srst_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pm_req,
   input  logic             bc_req,
   input  logic             expire,
   output sr_mode_t         mode_q,
   output logic             load,
   output logic             load_long,
   output logic [N_SRC-1:0] set_vec,
   output logic [N_SRC-1:0] clr_vec
);

   sr_mode_t mode_d;

   always_comb begin
      mode_d    = mode_q;
      load      = 1'b0;
      load_long = 1'b0;
      set_vec   = '0;
      clr_vec   = '0;
      unique case (mode_q)
         SR_IDLE: begin
            if (pm_req) begin
               mode_d          = SR_LONG;
               load            = 1'b1;
               load_long       = 1'b1;
               set_vec[SRC_PM] = 1'b1;
               set_vec[SRC_BC] = bc_req;
            end else if (bc_req) begin
               mode_d          = SR_SHORT;
               load            = 1'b1;
               set_vec[SRC_BC] = 1'b1;
            end
         end
         SR_SHORT: begin
            // A long request upgrades the running short reset
            if (pm_req) begin
               mode_d          = SR_LONG;
               load            = 1'b1;
               load_long       = 1'b1;
               set_vec[SRC_PM] = 1'b1;
            end else if (expire) begin
               mode_d  = SR_IDLE;
               clr_vec = '1;
            end
         end
         SR_LONG: begin
            if (expire) begin
               mode_d  = SR_IDLE;
               clr_vec = '1;
            end
         end
         default: begin
            mode_d  = SR_IDLE;
            clr_vec = '1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= SR_IDLE;
      else        mode_q <= mode_d;
   end

endmodule

// File: rtl/srst_flag.sv
module srst_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (set) q <= 1'b1;
   end

endmodule

// File: rtl/phy_srst_seq.sv
module phy_srst_seq
   import phy_srst_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 2000,
   parameter int unsigned SHORT_TICKS = 256,
   parameter int unsigned TICK_DIV    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic pm_wr_en,
   input  logic pm_wr_data,
   input  logic bc_wr_en,
   input  logic bc_wr_data,
   output logic pm_rst_bit,
   output logic bc_rst_bit,
   output logic phy_soft_rst,
   output logic sticky_clr
);

   localparam int unsigned CNT_W = cnt_width(LONG_TICKS);

   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (LONG_TICKS < SHORT_TICKS) begin : g_bad_long
         $error("LONG_TICKS must not be below SHORT_TICKS");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic             tick_int;
   logic             expire;
   logic             load;
   logic             load_long;
   logic [CNT_W-1:0] cnt_q;
   logic [N_SRC-1:0] set_vec;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] flag_q;
   sr_mode_t         mode_q;

   srst_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (tick_us),
      .tick_out (tick_int)
   );

   srst_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pm_req    (pm_wr_en && pm_wr_data),
      .bc_req    (bc_wr_en && bc_wr_data),
      .expire    (expire),
      .mode_q    (mode_q),
      .load      (load),
      .load_long (load_long),
      .set_vec   (set_vec),
      .clr_vec   (clr_vec)
   );

   srst_dur_cnt #(
      .CNT_W       (CNT_W),
      .LONG_TICKS  (LONG_TICKS),
      .SHORT_TICKS (SHORT_TICKS)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_long (load_long),
      .run       (mode_q != SR_IDLE),
      .tick      (tick_int),
      .expire    (expire),
      .cnt_q     (cnt_q)
   );

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_flag
         srst_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[i]),
            .clr   (clr_vec[i]),
            .q     (flag_q[i])
         );
      end
   endgenerate

   assign pm_rst_bit   = flag_q[SRC_PM];
   assign bc_rst_bit   = flag_q[SRC_BC];
   assign phy_soft_rst = (mode_q != SR_IDLE);
   assign sticky_clr   = (mode_q == SR_LONG);

endmodule

// File: rtl/phy_srst_seq_chk.sv
module phy_srst_seq_chk #(
   parameter int unsigned LONG_TICKS = 2000,
   parameter int unsigned CNT_W      = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_int,
   input logic             pm_wr_en,
   input logic             pm_wr_data,
   input logic             bc_wr_en,
   input logic             bc_wr_data,
   input logic             pm_rst_bit,
   input logic             bc_rst_bit,
   input logic             phy_soft_rst,
   input logic             sticky_clr,
   input logic [CNT_W-1:0] cnt_q
);

   assert_out_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      phy_soft_rst == (pm_rst_bit || bc_rst_bit));

   assert_pm_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_wr_en && pm_wr_data && !pm_rst_bit) |=> (pm_rst_bit && sticky_clr));

   assert_bc_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_wr_en && bc_wr_data && !phy_soft_rst && !pm_wr_en) |=> (bc_rst_bit && !sticky_clr));

   assert_sticky_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_clr |-> pm_rst_bit);

   assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_int && !(pm_wr_en && pm_wr_data) && !(bc_wr_en && bc_wr_data))
      |=> $stable({pm_rst_bit, bc_rst_bit}));

   assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_soft_rst) |-> $past(tick_int));

   assert_clear_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_rst_bit && bc_rst_bit) |=> (pm_rst_bit == bc_rst_bit));

   assert_ignore_bc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_rst_bit && !bc_rst_bit) |=> !bc_rst_bit);

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LONG_TICKS));

endmodule

bind phy_srst_seq phy_srst_seq_chk #(
   .LONG_TICKS (LONG_TICKS),
   .CNT_W      (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_int     (tick_int),
   .pm_wr_en     (pm_wr_en),
   .pm_wr_data   (pm_wr_data),
   .bc_wr_en     (bc_wr_en),
   .bc_wr_data   (bc_wr_data),
   .pm_rst_bit   (pm_rst_bit),
   .bc_rst_bit   (bc_rst_bit),
   .phy_soft_rst (phy_soft_rst),
   .sticky_clr   (sticky_clr),
   .cnt_q        (cnt_q)
);

// File: tb/phy_srst_seq_test.sv
`timescale 1ns/1ps
module phy_srst_seq_test;

   localparam int LONG  = 2000;
   localparam int SHORT = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic pm_wr_en = 1'b0, pm_wr_data = 1'b0;
   logic bc_wr_en = 1'b0, bc_wr_data = 1'b0;
   logic pm_rst_bit, bc_rst_bit, phy_soft_rst, sticky_clr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   phy_srst_seq uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_us      (tick_us),
      .pm_wr_en     (pm_wr_en),
      .pm_wr_data   (pm_wr_data),
      .bc_wr_en     (bc_wr_en),
      .bc_wr_data   (bc_wr_data),
      .pm_rst_bit   (pm_rst_bit),
      .bc_rst_bit   (bc_rst_bit),
      .phy_soft_rst (phy_soft_rst),
      .sticky_clr   (sticky_clr)
   );

   // Compare {pm, bc, rst, sticky} against the expected pattern
   task automatic expect4(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {pm_rst_bit, bc_rst_bit, phy_soft_rst, sticky_clr};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s {pm,bc,rst,sticky} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge
   task automatic wr(input logic pm_en, input logic pm_d, input logic bc_en, input logic bc_d);
      pm_wr_en = pm_en; pm_wr_data = pm_d;
      bc_wr_en = bc_en; bc_wr_data = bc_d;
      @(negedge clk);
      pm_wr_en = 1'b0; pm_wr_data = 1'b0;
      bc_wr_en = 1'b0; bc_wr_data = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         tick_us = 1'b1;
         repeat (n) @(negedge clk);
         tick_us = 1'b0;
      end
   endtask

   task automatic t_reset;
      expect4("R1 during reset", 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      expect4("R1 after reset", 4'b0000);
   endtask

   task automatic t_long;
      wr(1, 1, 0, 0);
      expect4("R2 long start", 4'b1011);
      ticks(LONG - 1);
      expect4("R3 one tick before end", 4'b1011);
      repeat (20) @(negedge clk);
      expect4("R3 no tick no end", 4'b1011);
      ticks(1);
      expect4("R3 long end", 4'b0000);
   endtask

   task automatic t_short;
      wr(0, 0, 1, 1);
      expect4("R4 short start", 4'b0110);
      ticks(SHORT - 1);
      expect4("R4 sticky stays low near end", 4'b0110);
      ticks(1);
      expect4("R5 short end", 4'b0000);
   endtask

   task automatic t_zero_write;
      wr(1, 0, 1, 0);
      expect4("R6 zero write idle", 4'b0000);
      ticks(5);
      expect4("R6 idle ticks", 4'b0000);
      wr(0, 0, 1, 1);
      ticks(10);
      wr(0, 0, 1, 0);
      expect4("R6 zero to bc during short", 4'b0110);
      wr(1, 0, 0, 0);
      expect4("R6 zero to pm during short", 4'b0110);
      ticks(SHORT - 11);
      expect4("R6 timing unchanged before end", 4'b0110);
      ticks(1);
      expect4("R6 timing unchanged end", 4'b0000);
   endtask

   task automatic t_no_restart;
      wr(0, 0, 1, 1);
      ticks(100);
      wr(0, 0, 1, 1);
      ticks(SHORT - 101);
      expect4("R7 short not restarted before end", 4'b0110);
      ticks(1);
      expect4("R7 short not restarted end", 4'b0000);
      wr(1, 1, 0, 0);
      ticks(700);
      wr(1, 1, 0, 0);
      ticks(LONG - 701);
      expect4("R7 long not restarted before end", 4'b1011);
      ticks(1);
      expect4("R7 long not restarted end", 4'b0000);
   endtask

   task automatic t_upgrade;
      wr(0, 0, 1, 1);
      ticks(50);
      wr(1, 1, 0, 0);
      expect4("R8 upgrade start", 4'b1111);
      ticks(SHORT);
      expect4("R8 short expiry passed", 4'b1111);
      ticks(LONG - SHORT - 1);
      expect4("R8 one tick before end", 4'b1111);
      ticks(1);
      expect4("R8 both clear together", 4'b0000);
   endtask

   task automatic t_bc_in_long;
      wr(1, 1, 0, 0);
      ticks(10);
      wr(0, 0, 1, 1);
      expect4("R9 bc ignored in long", 4'b1011);
      ticks(LONG - 11);
      expect4("R9 long runs on", 4'b1011);
      ticks(1);
      expect4("R9 long end", 4'b0000);
   endtask

   task automatic t_both;
      wr(1, 1, 1, 1);
      expect4("R10 both start", 4'b1111);
      ticks(SHORT);
      expect4("R10 no short end", 4'b1111);
      ticks(LONG - SHORT);
      expect4("R10 both end", 4'b0000);
      expect4("R11 idle output", {2'b00, pm_rst_bit | bc_rst_bit, 1'b0});
   endtask

   initial begin
      t_reset();
      t_long();
      t_short();
      t_zero_write();
      t_no_restart();
      t_upgrade();
      t_bc_in_long();
      t_both();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule